// File: doc/BRIEF.md
# Broadcast Weighted Vector Writer

This sequential unit takes two four-element operand vectors, x and y, as 32-bit two's-complement integers. It adds the four y elements into one scale factor and multiplies each x element by that factor. The four-element scaled vector is then written into a run of consecutive registers that begins at a destination base address. An immediate operand sets how many times the vector is repeated back to back. All sums and products are taken modulo 2^32.

A start pulse loads the operands. The unit then drives a simple register-file write port, one register per cycle in ascending address order, and raises a done pulse once the run has ended. In accumulate mode the unit also drives a read port. Each destination register then receives its old contents plus the scaled element. The single exception is the first register of the run, which is always overwritten. The read port returns data one cycle after the request, and the read for the next register overlaps the write of the current one.

Top module: `bwv_writer`

## Requirements
- R1: While reset is asserted, and in any cycle with no operation in progress, `rf_we_o`, `rf_re_o`, `done_o` and `busy_o` are all low.
- R2: Lane i of `x_i` and `y_i` sits at bits [32i+31:32i]. The scaled element e_i is x_i * (y_0+y_1+y_2+y_3) mod 2^32. Write number j of an operation goes to address (base + j) mod 256 and carries e_(j mod 4), before any accumulate term is added.
- R3: With `imm_i` no larger than 160, one operation makes exactly 4 * (1 << (imm_i / 32)) writes. The writes fall in consecutive cycles with ascending addresses, and the first write occurs in the cycle after the edge that accepts start.
- R4: A value of `imm_i` above 160 acts as 160, giving 32 copies and 128 writes.
- R5: With `acc_i` = 0 when the operation is accepted, every written register receives the bare element and `rf_re_o` stays low for the whole operation.
- R6: With `acc_i` = 1, every written register except the first receives its previous contents plus the element. The first register of the run is overwritten with the bare element.
- R7: In accumulate mode, `rf_re_o` is high in every write cycle except the last one, with `rf_raddr_o` equal to `rf_waddr_o` + 1. `rf_rdata_i` is taken in the following cycle, and an operation makes 4N-1 reads in total for N copies.
- R8: `done_o` is high for exactly one cycle, the cycle after the last write. `busy_o` is high from the first write cycle through the done cycle.
- R9: A start pulse that arrives while `busy_o` is high is ignored. This includes the done cycle: the pulse changes neither the written data nor the write count, and it does not begin a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| acc_i | input | 1 | 0 overwrite, 1 accumulate |
| imm_i | input | 8 | Replication immediate |
| base_i | input | 8 | First destination register address |
| x_i | input | 128 | Four x elements, lane 0 in the low bits |
| y_i | input | 128 | Four y elements, lane 0 in the low bits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 8 | Register write address |
| rf_wdata_o | output | 32 | Register write data |
| rf_re_o | output | 1 | Register read request (accumulate mode) |
| rf_raddr_o | output | 8 | Register read address |
| rf_rdata_i | input | 32 | Read data, valid one cycle after the request |

## Verification
In accumulate mode the unit reads register k+1 in the same cycle as it writes register k. If the address or the latency were off by one, a register would pick up a value already updated by the current run, or a stale one. The bench provokes this overlap with runs of 4 to 128 registers on top of a prefilled register-file model. It judges the result by comparing every one of the 256 registers with an image computed from the requirements. A second overlap occurs when a start pulse lands in a busy cycle or in the done cycle itself. The bench drives both cases and checks the write count, the register contents and the return of `busy_o` to low.

// File: rtl/bwv_pkg.sv
package bwv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bwv_state_e;

endpackage

// File: rtl/bwv_scale.sv
// Latches x and the y sum on load; lane products are combinational from the latches.
module bwv_scale #(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [LANES-1:0][DW-1:0]   x_i,
  input  logic [LANES-1:0][DW-1:0]   y_i,
  output logic [LANES-1:0][DW-1:0]   elem_o
);

  logic [LANES-1:0][DW-1:0] x_q;
  logic [DW-1:0]            sum_d, sum_q;

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < LANES; i++) sum_d = sum_d + y_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      sum_q <= '0;
    end else if (load_i) begin
      x_q   <= x_i;
      sum_q <= sum_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign elem_o[g] = x_q[g] * sum_q;
  end

endmodule

// File: rtl/bwv_seq.sv
// Run control: copy count from clamped immediate, write index, done pulse.
module bwv_seq
  import bwv_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int AW       = 8,
  parameter int IMM_W    = 8,
  parameter int IMM_MAX  = 160,
  parameter int IMM_STEP = 32,
  parameter int CNT_W    = 8,
  parameter int SHW      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             acc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AW-1:0]    base_i,
  output logic             load_o,
  output logic             run_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             acc_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [AW-1:0]    base_o
);

  bwv_state_e       state_q;
  logic [CNT_W-1:0] idx_q, last_q, last_d, total_d;
  logic [IMM_W-1:0] imm_c;
  logic [SHW-1:0]   sh_d;
  logic             acc_q;
  logic [AW-1:0]    base_q;

  always_comb begin
    imm_c   = (imm_i > IMM_W'(IMM_MAX)) ? IMM_W'(IMM_MAX) : imm_i;
    sh_d    = SHW'(imm_c / IMM_W'(IMM_STEP));
    total_d = CNT_W'(LANES) << sh_d;
    last_d  = total_d - 1'b1;
  end

  assign load_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      acc_q   <= 1'b0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
          last_q  <= last_d;
          acc_q   <= acc_i;
          base_q  <= base_i;
        end
        ST_RUN: begin
          if (idx_q == last_q) state_q <= ST_DONE;
          else                 idx_q   <= idx_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign last_o = run_o && (idx_q == last_q);
  assign done_o = (state_q == ST_DONE);
  assign busy_o = (state_q != ST_IDLE);
  assign acc_o  = acc_q;
  assign idx_o  = idx_q;
  assign base_o = base_q;

endmodule

// File: rtl/bwv_wport.sv
// Register-file port drive. Read of idx+1 overlaps write of idx; LANES must be a power of two.
module bwv_wport #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int CNT_W = 8,
  localparam int LW   = $clog2(LANES)
) (
  input  logic                     run_i,
  input  logic                     last_i,
  input  logic                     acc_i,
  input  logic [CNT_W-1:0]         idx_i,
  input  logic [AW-1:0]            base_i,
  input  logic [LANES-1:0][DW-1:0] elem_i,
  input  logic [DW-1:0]            rdata_i,
  output logic                     we_o,
  output logic [AW-1:0]            waddr_o,
  output logic [DW-1:0]            wdata_o,
  output logic                     re_o,
  output logic [AW-1:0]            raddr_o
);

  logic [LW-1:0] lane;
  logic [DW-1:0] old_term;

  assign lane     = idx_i[LW-1:0];
  assign old_term = (acc_i && (idx_i != '0)) ? rdata_i : '0;

  assign we_o    = run_i;
  assign waddr_o = base_i + AW'(idx_i);
  assign wdata_o = elem_i[lane] + old_term;
  assign re_o    = run_i && acc_i && !last_i;
  assign raddr_o = waddr_o + 1'b1;

endmodule

// File: rtl/bwv_writer.sv
module bwv_writer #(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int LANES    = 4,
  parameter int IMM_W    = 8,
  parameter int IMM_MAX  = 160,
  parameter int IMM_STEP = 32,
  localparam int MAX_SH  = IMM_MAX / IMM_STEP,
  localparam int TOT_MAX = LANES << MAX_SH,
  localparam int CNT_W   = $clog2(TOT_MAX),
  localparam int SHW     = $clog2(MAX_SH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                acc_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [AW-1:0]       base_i,
  input  logic [LANES*DW-1:0] x_i,
  input  logic [LANES*DW-1:0] y_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                rf_we_o,
  output logic [AW-1:0]       rf_waddr_o,
  output logic [DW-1:0]       rf_wdata_o,
  output logic                rf_re_o,
  output logic [AW-1:0]       rf_raddr_o,
  input  logic [DW-1:0]       rf_rdata_i
);

  logic                     load, run, last, acc_q;
  logic [CNT_W-1:0]         idx;
  logic [AW-1:0]            base_q;
  logic [LANES-1:0][DW-1:0] x_v, y_v, elem;

  assign x_v = x_i;
  assign y_v = y_i;

  bwv_seq #(
    .LANES(LANES), .AW(AW), .IMM_W(IMM_W), .IMM_MAX(IMM_MAX),
    .IMM_STEP(IMM_STEP), .CNT_W(CNT_W), .SHW(SHW)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .acc_i, .imm_i, .base_i,
    .load_o(load), .run_o(run), .last_o(last), .busy_o, .done_o,
    .acc_o(acc_q), .idx_o(idx), .base_o(base_q)
  );

  bwv_scale #(.DW(DW), .LANES(LANES)) u_scale (
    .clk_i, .rst_ni, .load_i(load), .x_i(x_v), .y_i(y_v), .elem_o(elem)
  );

  bwv_wport #(.DW(DW), .AW(AW), .LANES(LANES), .CNT_W(CNT_W)) u_wport (
    .run_i(run), .last_i(last), .acc_i(acc_q), .idx_i(idx), .base_i(base_q),
    .elem_i(elem), .rdata_i(rf_rdata_i),
    .we_o(rf_we_o), .waddr_o(rf_waddr_o), .wdata_o(rf_wdata_o),
    .re_o(rf_re_o), .raddr_o(rf_raddr_o)
  );

endmodule

// File: rtl/bwv_writer_chk.sv
module bwv_writer_chk #(
  parameter int AW     = 8,
  parameter int WR_CAP = 128,
  localparam int CW    = $clog2(WR_CAP + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          rf_we_o,
  input logic [AW-1:0] rf_waddr_o,
  input logic          rf_re_o,
  input logic [AW-1:0] rf_raddr_o
);

  logic [CW-1:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_cnt_q <= '0;
    else if (done_o)  wr_cnt_q <= '0;
    else if (rf_we_o) wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rf_we_o && !rf_re_o && !done_o));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && $past(rf_we_o)) |-> (rf_waddr_o == AW'($past(rf_waddr_o) + 1'b1)));

  assert_first_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !$past(rf_we_o)) |-> ($past(start_i) && !$past(busy_o)));

  assert_write_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_q <= CW'(WR_CAP));

  assert_read_ahead_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_re_o |-> (rf_we_o && rf_raddr_o == AW'(rf_waddr_o + 1'b1)));

  assert_done_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rf_we_o && $past(rf_we_o)));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

endmodule

bind bwv_writer bwv_writer_chk #(.AW(AW), .WR_CAP(TOT_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
  .rf_re_o(rf_re_o), .rf_raddr_o(rf_raddr_o)
);

// File: tb/bwv_writer_tb.sv
module bwv_writer_tb;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         acc_i = 1'b0;
  logic [7:0]   imm_i = '0;
  logic [7:0]   base_i = '0;
  logic [127:0] x_i = '0;
  logic [127:0] y_i = '0;
  logic         busy_o, done_o, rf_we_o, rf_re_o;
  logic [7:0]   rf_waddr_o, rf_raddr_o;
  logic [31:0]  rf_wdata_o;
  logic [31:0]  rf_rdata_i;

  always #10 clk_i = ~clk_i;

  bwv_writer u_dut (
    .clk_i, .rst_ni, .start_i, .acc_i, .imm_i, .base_i, .x_i, .y_i,
    .busy_o, .done_o, .rf_we_o, .rf_waddr_o, .rf_wdata_o,
    .rf_re_o, .rf_raddr_o, .rf_rdata_i
  );

  // register-file model, prefilled during reset, one-cycle read latency
  logic [31:0] mem [256];
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int a = 0; a < 256; a++) mem[a] <= 32'(a) * 32'h0100_0193 + 32'h55;
      rf_rdata_i <= '0;
    end else begin
      if (rf_re_o) rf_rdata_i <= mem[rf_raddr_o];
      if (rf_we_o) mem[rf_waddr_o] <= rf_wdata_o;
    end
  end

  int n_chk = 0, n_bad = 0;
  int cnt_we = 0, cnt_re = 0;
  always @(negedge clk_i) begin
    if (rf_we_o) cnt_we++;
    if (rf_re_o) cnt_re++;
  end

  logic [31:0] exp_m [256];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int copies_n(input logic [7:0] imm);
    int c = (imm > 8'd160) ? 160 : int'(imm);
    return 4 * (1 << (c / 32));
  endfunction

  task automatic calc_exp(input bit acc, input logic [7:0] imm, input logic [7:0] base,
                          input logic [127:0] xv, input logic [127:0] yv);
    logic [31:0] s, e;
    int n = copies_n(imm);
    s = yv[31:0] + yv[63:32] + yv[95:64] + yv[127:96];
    for (int a = 0; a < 256; a++) exp_m[a] = mem[a];
    for (int j = 0; j < n; j++) begin
      e = xv[32*(j%4) +: 32] * s;
      exp_m[(int'(base) + j) % 256] = (acc && j != 0) ? exp_m[(int'(base) + j) % 256] + e : e;
    end
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== exp_m[a]) d++;
    return d;
  endfunction

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 3000) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic run_op(input bit acc, input logic [7:0] imm, input logic [7:0] base,
                        input logic [127:0] xv, input logic [127:0] yv);
    int n = copies_n(imm);
    int cyc;
    calc_exp(acc, imm, base, xv, yv);
    @(negedge clk_i);
    cnt_we = 0; cnt_re = 0;
    start_i = 1'b1; acc_i = acc; imm_i = imm; base_i = base; x_i = xv; y_i = yv;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1 && rf_we_o === 1'b1, "R3 first write", rf_we_o, 1);
    wait_done(cyc);
    check(cyc == n, "R8 done after last write", cyc, n);
    check(cnt_we == n, (imm > 8'd160) ? "R4 clamped count" : "R3 write count", cnt_we, n);
    check(cnt_re == (acc ? n - 1 : 0), acc ? "R7 read count" : "R5 no reads",
          cnt_re, acc ? n - 1 : 0);
    check(mem_diff() == 0, acc ? "R6 accumulate image" : "R2 overwrite image", mem_diff(), 0);
    @(negedge clk_i);
    check(done_o === 1'b0 && busy_o === 1'b0, "R8 single done", done_o, 0);
  endtask

  localparam int NV = 7;
  localparam logic        T_ACC  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [7:0]  T_IMM  [NV] = '{8'd0, 8'd40, 8'd0, 8'd70, 8'd255, 8'd160, 8'd159};
  localparam logic [7:0]  T_BASE [NV] = '{8'h10, 8'h30, 8'h10, 8'h40, 8'd200, 8'h05, 8'h80};
  localparam logic [127:0] T_X [NV] = '{
    {32'd100, 32'd7, 32'hFFFF_FFFE, 32'd3},
    {32'd8, 32'd7, 32'd6, 32'd5},
    {32'd1, 32'd2, 32'd3, 32'd4},
    {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd9},
    {32'd11, 32'd22, 32'd33, 32'd44},
    {32'h0001_0001, 32'd0, 32'hFFFF_FF00, 32'd13},
    {32'd5, 32'd5, 32'd5, 32'd5}};
  localparam logic [127:0] T_Y [NV] = '{
    {32'd4, 32'd3, 32'd2, 32'd1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'd0, 32'd0, 32'd0, 32'd2},
    {32'd1, 32'd1, 32'd1, 32'd0},
    {32'd0, 32'd0, 32'd0, 32'd0},
    {32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h4000_0003},
    {32'd1, 32'd2, 32'd3, 32'hFFFF_FFF0}};

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk_i);
    check(rf_we_o === 1'b0 && rf_re_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0,
          "R1 in reset", {rf_we_o, rf_re_o, done_o, busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rf_we_o === 1'b0 && busy_o === 1'b0, "R1 after reset", {rf_we_o, busy_o}, 0);

    for (int v = 0; v < NV; v++) run_op(T_ACC[v], T_IMM[v], T_BASE[v], T_X[v], T_Y[v]);

    // R9: start pulses during run and during the done cycle are ignored
    calc_exp(1'b0, 8'd32, 8'h60, T_X[1], T_Y[0]);
    @(negedge clk_i);
    cnt_we = 0; cnt_re = 0;
    start_i = 1'b1; acc_i = 1'b0; imm_i = 8'd32; base_i = 8'h60; x_i = T_X[1]; y_i = T_Y[0];
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    start_i = 1'b1; acc_i = 1'b1; imm_i = 8'd255; base_i = 8'h00; x_i = T_X[3]; y_i = T_Y[5];
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(cyc);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b0, "R9 start in done cycle", busy_o, 0);
    check(cnt_we == 8, "R9 write count", cnt_we, 8);
    check(cnt_re == 0, "R9 no reads", cnt_re, 0);
    check(mem_diff() == 0, "R9 image unchanged by late start", mem_diff(), 0);
    repeat (2) @(negedge clk_i);
    check(rf_we_o === 1'b0 && busy_o === 1'b0, "R1 idle after ignored start", busy_o, 0);

    // single copy of accumulate mode: only the overwritten first register plus three sums
    run_op(1'b1, 8'd31, 8'hFE, T_X[4], T_Y[2]);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule